// File: doc/BRIEF.md
# Configurable Multi-Term Multiply-Accumulate Unit

This block forms one result word from several arithmetic terms, a bus of single-bit increments and nothing else. Each term is either a product of two operand slices or one operand slice used on its own. Each term is added to or subtracted from a running sum that starts at zero. All term operands arrive packed side by side on one wide input bus. An elaboration-time configuration vector gives the number of terms, the two slice widths of each term, whether the term is treated as signed, and whether it is subtracted.

The configuration is decoded entirely at elaboration. The block builds one term datapath per record and derives the width of the packed operand bus from the records. At run time the block is pure combinational logic: operands go in and the result comes out in the same evaluation, wrapped modulo 2^RES_W. It is meant to sit behind synthesis-generated arithmetic or in a hand-built datapath that needs a fused sum of products with a few carry-in style bits.

Top module: `macc_unit`

## Requirements
- R1: Configuration bits [3:0], least significant bit first, give N, the width of every size field in the term records.
- R2: Term records follow the header back to back, each 2+2N bits wide. Record bit 0 is the signed flag, record bit 1 is the subtract flag, the next N bits are the A size and the N bits after that are the B size, each size least significant bit first. The number of terms is (CFG_W-4)/(2+2N).
- R3: Operand slices are taken from the packed bus starting at bit 0 in record order. Each term's A slice comes first and its B slice sits directly above it. The bus width equals the sum of all A and B sizes.
- R4: A term whose B size is zero contributes its A operand. Any other term contributes the product A*B.
- R5: A set signed flag sign-extends both operands of the term to RES_W bits before the multiply. A clear flag zero-extends them.
- R6: A set subtract flag subtracts the term's contribution from the sum. A clear flag adds it.
- R7: Every bit of the increment bus adds 0 or 1, unsigned, to the result.
- R8: The sum starts at zero and wraps modulo 2^RES_W, so all-zero inputs give a zero result.
- R9: A record with both sizes zero consumes no bus bits and contributes nothing.
- R10: The result is combinational and follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_bus | input | PACK_W (21 by default) | Packed operand slices of all terms |
| inc_bits | input | INC_W | Single-bit increments, each added as 0 or 1 |
| result | output | RES_W | Accumulated sum modulo 2^RES_W |

## Verification
The hardest case to reach from the ports is a narrow signed operand holding its most negative value while the other operand of the same product is also negative. Only then does a missing or wrong sign extension change the product without also disturbing the other terms in an obvious way. Directed vectors place -8 on both slices of the signed product and -4 on the subtracted signed direct term, and every other slice is held at zero so that each term is seen alone. Fixed-seed random vectors over the whole packed bus then mix all terms and increments. This also exercises the slice boundaries and the zero-size record at the same time.

// File: rtl/macc_pkg.sv
// Package macc_pkg
// Elaboration-time decoding of the term configuration vector.
// Assumes the vector is well formed: a 4-bit header followed by whole records.
package macc_pkg;

    localparam int CFG_MAX = 512;
    localparam int HDR_W   = 4;

    // Read an n-bit unsigned field, lsb first, starting at bit pos.
    function automatic int get_field(logic [CFG_MAX-1:0] c, int pos, int n);
        int v;
        v = 0;
        for (int i = 0; i < n; i++)
            if (c[pos + i]) v += (1 << i);
        return v;
    endfunction

    function automatic int rec_width(int nb);
        return 2 + 2 * nb;
    endfunction

    function automatic int rec_base(int nb, int k);
        return HDR_W + k * rec_width(nb);
    endfunction

    function automatic int size_field_w(logic [CFG_MAX-1:0] c);
        return get_field(c, 0, HDR_W);
    endfunction

    function automatic int term_count(int cfg_w, int nb);
        return (cfg_w - HDR_W) / rec_width(nb);
    endfunction

    function automatic int a_size(logic [CFG_MAX-1:0] c, int nb, int k);
        return get_field(c, rec_base(nb, k) + 2, nb);
    endfunction

    function automatic int b_size(logic [CFG_MAX-1:0] c, int nb, int k);
        return get_field(c, rec_base(nb, k) + 2 + nb, nb);
    endfunction

    function automatic bit is_signed_term(logic [CFG_MAX-1:0] c, int nb, int k);
        return c[rec_base(nb, k)];
    endfunction

    function automatic bit is_sub_term(logic [CFG_MAX-1:0] c, int nb, int k);
        return c[rec_base(nb, k) + 1];
    endfunction

    // Bus offset of term k: total of the sizes of every earlier term.
    function automatic int term_offset(logic [CFG_MAX-1:0] c, int nb, int k);
        int off;
        off = 0;
        for (int j = 0; j < k; j++)
            off += a_size(c, nb, j) + b_size(c, nb, j);
        return off;
    endfunction

    function automatic int packed_width(logic [CFG_MAX-1:0] c, int cfg_w);
        int nb;
        nb = size_field_w(c);
        return term_offset(c, nb, term_count(cfg_w, nb));
    endfunction

endpackage

// File: rtl/macc_ext.sv
// Module macc_ext
// Widens or truncates one operand slice to the result width.
// Sign-extends when SGN is set and zero-extends otherwise. Assumes IN_W >= 1.
module macc_ext #(
    parameter int IN_W  = 4,
    parameter int RES_W = 12,
    parameter bit SGN   = 1'b0
) (
    input  logic [IN_W-1:0]  din,
    output logic [RES_W-1:0] dout
);

    generate
        if (IN_W >= RES_W) begin : g_trunc
            // Keep the low result bits; the wrap makes the upper ones irrelevant.
            assign dout = din[RES_W-1:0];
        end else begin : g_widen
            logic fill;
            // Fill bit for the upper part of the widened operand.
            assign fill = SGN ? din[IN_W-1] : 1'b0;
            assign dout = {{(RES_W-IN_W){fill}}, din};

            // Check that the extended value keeps the slice and its sign sense.
            always_comb begin
                if (!$isunknown(din)) begin
                    a_r5_low_kept: assert (dout[IN_W-1:0] == din)
                        else $error("R5 operand bits altered");
                    if (SGN) begin
                        a_r5_sign_ext: assert ((&dout[RES_W-1:IN_W-1]) || (~|dout[RES_W-1:IN_W-1]))
                            else $error("R5 signed extension broken");
                    end else begin
                        a_r5_zero_ext: assert (~|dout[RES_W-1:IN_W])
                            else $error("R5 unsigned extension broken");
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/macc_term.sv
// Module macc_term
// One configured term: slices A and B from the packed bus, extends them,
// and forms the signed-sense contribution (direct A or A*B, negated when
// subtracting). Assumes OFF+ASZ+BSZ <= PACK_W.
module macc_term #(
    parameter int PACK_W = 21,
    parameter int RES_W  = 12,
    parameter int OFF    = 0,
    parameter int ASZ    = 4,
    parameter int BSZ    = 4,
    parameter bit SGN    = 1'b0,
    parameter bit SUB    = 1'b0
) (
    input  logic [PACK_W-1:0] bus,
    output logic [RES_W-1:0]  contrib
);

    logic [RES_W-1:0] a_ext;
    logic [RES_W-1:0] b_ext;
    logic [RES_W-1:0] mag;

    generate
        if (ASZ == 0) begin : g_a_none
            assign a_ext = '0;
        end else begin : g_a
            macc_ext #(.IN_W(ASZ), .RES_W(RES_W), .SGN(SGN)) u_ext_a (
                .din  (bus[OFF +: ASZ]),
                .dout (a_ext)
            );
        end

        if (BSZ == 0) begin : g_direct
            // No B slice: the term is the A operand itself.
            assign b_ext = '0;
            assign mag   = a_ext;
        end else begin : g_mul
            macc_ext #(.IN_W(BSZ), .RES_W(RES_W), .SGN(SGN)) u_ext_b (
                .din  (bus[OFF+ASZ +: BSZ]),
                .dout (b_ext)
            );
            // Product at result width; wrap is exact for both signed and unsigned.
            assign mag = a_ext * b_ext;
        end

        if (SUB) begin : g_neg
            assign contrib = '0 - mag;
        end else begin : g_pos
            assign contrib = mag;
        end
    endgenerate

    // Check the zero operand and the add/subtract sense of the contribution.
    always_comb begin
        if (!$isunknown(bus)) begin
            a_r4_zero_operand: assert ((a_ext != '0) || (contrib == '0))
                else $error("R4 zero A operand gave nonzero term");
            if (SUB) begin
                a_r6_negated: assert ((contrib + mag) == '0)
                    else $error("R6 subtract sense wrong");
            end else begin
                a_r6_plain: assert ((contrib ^ mag) == '0)
                    else $error("R6 add sense wrong");
            end
        end
    end

endmodule

// File: rtl/macc_inc.sv
// Module macc_inc
// Counts the set bits of the increment bus at the result width.
// Assumes INC_W >= 1.
module macc_inc #(
    parameter int INC_W = 3,
    parameter int RES_W = 12
) (
    input  logic [INC_W-1:0] inc,
    output logic [RES_W-1:0] cnt
);

    // Add each increment bit as an unsigned 0 or 1.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < INC_W; i++)
            cnt = cnt + RES_W'(inc[i]);
    end

    // Check the count against an independent population count.
    always_comb begin
        if (!$isunknown(inc)) begin
            a_r7_popcount: assert (cnt == RES_W'($countones(inc)))
                else $error("R7 increment count wrong");
        end
    end

endmodule

// File: rtl/macc_unit.sv
// Module macc_unit
// Configurable multi-term multiply-accumulate. The configuration vector is
// decoded at elaboration; one macc_term is built per record and all
// contributions plus the increment count are summed modulo 2^RES_W.
// Assumes a well-formed vector with at least one record and INC_W >= 1.
module macc_unit #(
    parameter int RES_W = 12,
    parameter int INC_W = 3,
    parameter int CFG_W = 54,
    parameter logic [CFG_W-1:0] CFG = {
        {4'd0, 4'd0, 1'b0, 1'b0},
        {4'd0, 4'd3, 1'b1, 1'b1},
        {4'd0, 4'd5, 1'b0, 1'b0},
        {4'd2, 4'd3, 1'b1, 1'b0},
        {4'd4, 4'd4, 1'b0, 1'b1},
        4'd4
    },
    localparam int PACK_W = macc_pkg::packed_width(
        {{(macc_pkg::CFG_MAX-CFG_W){1'b0}}, CFG}, CFG_W)
) (
    input  logic [PACK_W-1:0] opnd_bus,
    input  logic [INC_W-1:0]  inc_bits,
    output logic [RES_W-1:0]  result
);

    localparam logic [macc_pkg::CFG_MAX-1:0] CFGX =
        {{(macc_pkg::CFG_MAX-CFG_W){1'b0}}, CFG};
    localparam int NB = macc_pkg::size_field_w(CFGX);
    localparam int NT = macc_pkg::term_count(CFG_W, NB);

    logic [RES_W-1:0] term_val [NT];
    logic [RES_W-1:0] inc_cnt;

    generate
        for (genvar k = 0; k < NT; k++) begin : g_term
            macc_term #(
                .PACK_W (PACK_W),
                .RES_W  (RES_W),
                .OFF    (macc_pkg::term_offset(CFGX, NB, k)),
                .ASZ    (macc_pkg::a_size(CFGX, NB, k)),
                .BSZ    (macc_pkg::b_size(CFGX, NB, k)),
                .SGN    (macc_pkg::is_signed_term(CFGX, NB, k)),
                .SUB    (macc_pkg::is_sub_term(CFGX, NB, k))
            ) u_term (
                .bus     (opnd_bus),
                .contrib (term_val[k])
            );
        end
    endgenerate

    macc_inc #(.INC_W(INC_W), .RES_W(RES_W)) u_inc (
        .inc (inc_bits),
        .cnt (inc_cnt)
    );

    // Accumulate the increment count and every term contribution.
    always_comb begin
        result = inc_cnt;
        for (int k = 0; k < NT; k++)
            result = result + term_val[k];
    end

    // Check the zero start of the sum and the increments-only case.
    always_comb begin
        if (!$isunknown({opnd_bus, inc_bits})) begin
            a_r8_zero_start: assert ((opnd_bus != '0) || (inc_bits != '0) || (result == '0))
                else $error("R8 zero inputs gave nonzero result");
            a_r7_inc_only: assert ((opnd_bus != '0) || (result == inc_cnt))
                else $error("R7 increments-only result wrong");
        end
    end

endmodule

// File: tb/macc_unit_tb.sv
// Bench for macc_unit with the default configuration: term0 signed 4x4
// added, term1 unsigned 3x2 subtracted, term2 unsigned 5-bit direct added,
// term3 signed 3-bit direct subtracted, term4 empty. RES_W 12, INC_W 3.
module macc_unit_tb;

    logic        clk;
    logic        rst_n;
    logic [20:0] bus;
    logic [2:0]  inc;
    logic [11:0] res;
    int          n_checks;
    int          n_errors;
    bit          done;

    macc_unit u_dut (
        .opnd_bus (bus),
        .inc_bits (inc),
        .result   (res)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference from the requirements, with the field positions written out.
    function automatic logic [11:0] model(logic [20:0] x, logic [2:0] c);
        longint s;
        s = 0;
        s += longint'($signed(x[3:0])) * longint'($signed(x[7:4]));
        s -= longint'(x[10:8]) * longint'(x[12:11]);
        s += longint'(x[17:13]);
        s -= longint'($signed(x[20:18]));
        s += longint'(c[0]) + longint'(c[1]) + longint'(c[2]);
        return s[11:0];
    endfunction

    task automatic check(string req, logic [11:0] exp);
        n_checks++;
        if (res !== exp) begin
            n_errors++;
            $display("FAIL %s: result=%0d expected=%0d", req, res, exp);
        end
    endtask

    task automatic apply(logic [20:0] x, logic [2:0] c);
        @(negedge clk);
        bus = x;
        inc = c;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: result=%0d expected=%0d", res, 0);
        finish_run();
    end

    initial begin
        n_checks = 0;
        n_errors = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        bus      = '0;
        inc      = '0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R8: all-zero inputs give zero
        check("R8 zero", 12'd0);

        // R5 R4: signed product (-8)*(-8) = 64
        apply(21'h000088, 3'b000);
        check("R5 R4 signed product", 12'd64);
        // R5: (-8)*7 = -56 wraps to 4040
        apply(21'h000078, 3'b000);
        check("R5 mixed sign", 12'd4040);
        // R6 R8: unsigned 7*3 subtracted, -21 wraps to 4075
        apply(21'(5'b11111) << 8, 3'b000);
        check("R6 R8 subtract wrap", 12'd4075);
        // R4 R3: direct unsigned term at bits 17:13, value 31
        apply(21'(5'd31) << 13, 3'b000);
        check("R4 R3 direct term", 12'd31);
        // R5 R6: signed -4 subtracted gives +4
        apply(21'(3'b100) << 18, 3'b000);
        check("R5 R6 signed subtract", 12'd4);
        // R7: all increment bits set
        apply(21'd0, 3'b111);
        check("R7 increments", 12'd3);
        // R7: single increment bit
        apply(21'd0, 3'b010);
        check("R7 one increment", 12'd1);
        // R1 R2 R3 R9: all operand bits set, 1-21+31+1+3
        apply({21{1'b1}}, 3'b111);
        check("R1 R2 R3 R9 all ones", 12'd15);

        // R10: result follows an input change without a clock edge
        @(negedge clk);
        bus = 21'(5'd9) << 13;
        inc = 3'b001;
        #2;
        check("R10 combinational", 12'd10);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9: fixed-seed random mix
        for (int i = 0; i < 300; i++) begin
            logic [20:0] rx;
            logic [2:0]  rc;
            rx = 21'($urandom());
            rc = 3'($urandom());
            apply(rx, rc);
            check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", model(rx, rc));
        end

        finish_run();
    end

endmodule